// File: doc/BRIEF.md
# Banked Register File with Pointer Redirection

This block is the data memory of a small 8-bit processor core. It holds 512 bytes. An access is addressed in one of two ways. In a direct access, the 7-bit file address taken from the instruction word is extended with two bank-select bits. In an indirect access, the location is chosen by an 8-bit pointer register, with one extra high bank bit placed above it.

File address zero is not a storage location. It is a virtual port that redirects the access through the pointer. If the pointer itself holds zero, the access refers back to that virtual port. Such a self-referencing read returns zero, and such a write is discarded.

Writes take effect on the rising clock edge. Reads are combinational from the resolved address. The pointer register and the three bank bits are loaded through dedicated synchronous ports, so the program can change them between accesses. The resolved address and an indirect-access flag are brought out for checking.

Top module: `bank_regfile`

## Requirements
- R1: After reset, the pointer register and all three bank bits are zero. Presenting file address 0 then gives isIndirect=1, effAddr=0x000 and rdData=0x00.
- R2: A nonzero file address is a direct access. It gives isIndirect=0 and effAddr = {bank[1:0], fileAddr[6:0]}.
- R3: File address 0x00 is an indirect access. It gives isIndirect=1 and effAddr = {bank[2], pointer[7:0]}.
- R4: An indirect read whose pointer value is 0x00 returns 0x00, whatever bank[2] is and whatever is stored.
- R5: An indirect write whose pointer value is 0x00 changes no location in the memory.
- R6: When wrEn is high at a rising edge, wrData is stored at effAddr. When wrEn is low, nothing is stored.
- R7: rdData equals the byte stored at effAddr within the same cycle. This includes indirect reads with a nonzero pointer.
- R8: ptrLoad loads ptrIn, and bankLoad loads bankIn, at the rising edge. Until that edge the old values still steer the address.
- R9: bank[2] has no effect on direct accesses, and bank[1:0] have no effect on indirect accesses. A byte written through the pointer is therefore readable directly at the same 9-bit address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset of the pointer and the bank bits |
| fileAddr | input | 7 | File address from the instruction; 0 selects indirect access |
| wrEn | input | 1 | Write enable for the current access |
| wrData | input | 8 | Byte to write |
| rdData | output | 8 | Byte read from the resolved address (combinational) |
| ptrLoad | input | 1 | Load strobe for the pointer register |
| ptrIn | input | 8 | New pointer value |
| bankLoad | input | 1 | Load strobe for the bank bits |
| bankIn | input | 3 | New bank bits; bit 2 is the indirect high bit, bits 1:0 are the direct bank |
| effAddr | output | 9 | Resolved 9-bit memory address |
| isIndirect | output | 1 | High when the current access goes through the pointer |

## Verification
The bench builds the block with its default parameters: 8-bit data, an 8-bit pointer, a 7-bit file address and two direct bank bits. Together these give a 9-bit address space.

With those values the address-resolution vectors reach both ends of the space: 0x000, and 0x1FF through both the direct and the indirect path. The bench also crosses the two paths over the same locations, so a byte written through the pointer in the upper half is read back directly. It confirms that self-referencing writes disturb no byte that was written earlier.

// File: rtl/bank_regfile_pkg.sv
package bank_regfile_pkg;
  parameter int DATA_W  = 8;
  parameter int PTR_W   = 8;
  parameter int FILE_W  = 7;
  parameter int DBANK_W = 2;

  localparam int ADDR_W = PTR_W + 1;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int BANK_W = DBANK_W + 1;

  typedef struct packed {
    logic              memWe;
    logic              rdZero;
    logic [ADDR_W-1:0] addr;
  } fileStrobe_t;
endpackage

// File: rtl/bank_regfile_ctrl.sv
module bank_regfile_ctrl
  import bank_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [FILE_W-1:0] fileAddr,
  input  logic              wrEn,
  input  logic              ptrLoad,
  input  logic [PTR_W-1:0]  ptrIn,
  input  logic              bankLoad,
  input  logic [BANK_W-1:0] bankIn,
  output fileStrobe_t       strobe,
  output logic              indirect
);
  logic [PTR_W-1:0]  ptrQ;
  logic [BANK_W-1:0] bankQ;
  logic              ptrNull;

  // pointer and bank bits: dedicated synchronous loads
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ  <= '0;
      bankQ <= '0;
    end else begin
      if (ptrLoad)  ptrQ  <= ptrIn;
      if (bankLoad) bankQ <= bankIn;
    end
  end

  // address resolution: file address zero redirects through the pointer
  always_comb begin
    indirect = (fileAddr == '0);
    ptrNull  = (ptrQ == '0);
    if (indirect) strobe.addr = {bankQ[DBANK_W], ptrQ};
    else          strobe.addr = {bankQ[DBANK_W-1:0], fileAddr};
    strobe.rdZero = indirect && ptrNull;
    strobe.memWe  = wrEn && !strobe.rdZero;
  end

  assert_ptr_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    ptrLoad |=> ptrQ == $past(ptrIn));

  assert_bank_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    bankLoad |=> bankQ == $past(bankIn));

  assert_null_write_blocked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (indirect && ptrQ == '0) |-> !strobe.memWe);

  assert_direct_bank_R9: assert property (@(posedge clk) disable iff (!rstN)
    !indirect |-> strobe.addr[ADDR_W-1:FILE_W] == bankQ[DBANK_W-1:0]);

  assert_indirect_ptr_R3: assert property (@(posedge clk) disable iff (!rstN)
    indirect |-> strobe.addr[PTR_W-1:0] == ptrQ);
endmodule

// File: rtl/bank_regfile_dp.sv
module bank_regfile_dp
  import bank_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  fileStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.memWe) mem[strobe.addr] <= wrData;
  end

  always_comb begin
    rdData = strobe.rdZero ? '0 : mem[strobe.addr];
  end

  // bookkeeping for the write-landing check
  logic [ADDR_W-1:0] chkAddr;
  logic [DATA_W-1:0] chkData;
  logic              chkValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkValid <= 1'b0;
      chkAddr  <= '0;
      chkData  <= '0;
    end else begin
      chkValid <= strobe.memWe;
      chkAddr  <= strobe.addr;
      chkData  <= wrData;
    end
  end

  assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rstN)
    chkValid |-> mem[chkAddr] == chkData);

  assert_null_read_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdZero |-> rdData == '0);
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bank_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [FILE_W-1:0] fileAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              ptrLoad,
  input  logic [PTR_W-1:0]  ptrIn,
  input  logic              bankLoad,
  input  logic [BANK_W-1:0] bankIn,
  output logic [ADDR_W-1:0] effAddr,
  output logic              isIndirect
);
  fileStrobe_t strobe;

  bank_regfile_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fileAddr(fileAddr), .wrEn(wrEn),
    .ptrLoad(ptrLoad), .ptrIn(ptrIn), .bankLoad(bankLoad), .bankIn(bankIn),
    .strobe(strobe), .indirect(isIndirect)
  );

  bank_regfile_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .rdData(rdData)
  );

  assign effAddr = strobe.addr;

  assert_self_ref_no_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isIndirect && effAddr[PTR_W-1:0] == '0) |-> !strobe.memWe);

  assert_direct_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fileAddr != '0) |-> (!isIndirect && effAddr[FILE_W-1:0] == fileAddr));
endmodule

// File: tb/sim_bank_regfile.sv
module sim_bank_regfile;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] fileAddr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       ptrLoad = 1'b0;
  logic [7:0] ptrIn = '0;
  logic       bankLoad = 1'b0;
  logic [2:0] bankIn = '0;
  logic [8:0] effAddr;
  logic       isIndirect;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  bank_regfile u0 (
    .clk(clk), .rstN(rstN), .fileAddr(fileAddr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .ptrLoad(ptrLoad), .ptrIn(ptrIn), .bankLoad(bankLoad),
    .bankIn(bankIn), .effAddr(effAddr), .isIndirect(isIndirect)
  );

  // fields: bank(3) ptr(8) file(7) expAddr(9) expInd(1)
  localparam int NVEC = 8;
  localparam logic [27:0] VEC [NVEC] = '{
    {3'b000, 8'h00, 7'h15, 9'h015, 1'b0},
    {3'b011, 8'h00, 7'h7F, 9'h1FF, 1'b0},
    {3'b110, 8'h12, 7'h01, 9'h101, 1'b0},
    {3'b001, 8'h00, 7'h40, 9'h0C0, 1'b0},
    {3'b100, 8'h37, 7'h00, 9'h137, 1'b1},
    {3'b011, 8'hC8, 7'h00, 9'h0C8, 1'b1},
    {3'b111, 8'hFF, 7'h00, 9'h1FF, 1'b1},
    {3'b000, 8'h00, 7'h00, 9'h000, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic setPtrBank(input logic [2:0] b, input logic [7:0] p);
    bankIn = b; ptrIn = p; bankLoad = 1'b1; ptrLoad = 1'b1;
    tick();
    bankLoad = 1'b0; ptrLoad = 1'b0;
  endtask

  task automatic writeByte(input logic [6:0] f, input logic [7:0] d);
    fileAddr = f; wrData = d; wrEn = 1'b1;
    tick();
    wrEn = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rstN = 1'b1;
    tick();

    // R1: reset state seen through an indirect access
    fileAddr = 7'h00; #1;
    check("R1 isIndirect", isIndirect, 1);
    check("R1 effAddr", effAddr, 9'h000);
    check("R1 rdData", rdData, 8'h00);

    // vector walk: address resolution (R2 direct / R3 indirect)
    for (int i = 0; i < NVEC; i++) begin
      setPtrBank(VEC[i][27:25], VEC[i][24:17]);
      fileAddr = VEC[i][16:10]; #1;
      check(VEC[i][0] ? "R3 effAddr" : "R2 effAddr", effAddr, VEC[i][9:1]);
      check(VEC[i][0] ? "R3 isIndirect" : "R2 isIndirect", isIndirect, VEC[i][0]);
    end

    // R6/R7: direct write to 0x095, read back
    setPtrBank(3'b001, 8'h00);
    writeByte(7'h15, 8'hA5);
    fileAddr = 7'h15; #1;
    check("R6 direct write/readback", rdData, 8'hA5);

    // R7/R3: indirect read of 0x095 in the same cycle
    setPtrBank(3'b010, 8'h95);
    fileAddr = 7'h00; #1;
    check("R7 indirect read", rdData, 8'hA5);
    check("R9 direct bank ignored indirect", effAddr, 9'h095);

    // R9: indirect write to 0x123, direct read at bank 2 file 0x23
    setPtrBank(3'b100, 8'h23);
    writeByte(7'h00, 8'h3C);
    setPtrBank(3'b010, 8'h23);
    fileAddr = 7'h23; #1;
    check("R9 cross path read", rdData, 8'h3C);
    setPtrBank(3'b110, 8'h23);
    fileAddr = 7'h23; #1;
    check("R9 high bit ignored direct", rdData, 8'h3C);

    // R4/R5: self-referencing pointer
    setPtrBank(3'b000, 8'h00);
    writeByte(7'h00, 8'hFF);
    fileAddr = 7'h00; #1;
    check("R4 null read", rdData, 8'h00);
    setPtrBank(3'b100, 8'h00);
    writeByte(7'h00, 8'hEE);
    fileAddr = 7'h00; #1;
    check("R4 null read high bank", rdData, 8'h00);
    setPtrBank(3'b001, 8'h00);
    fileAddr = 7'h15; #1;
    check("R5 0x095 untouched", rdData, 8'hA5);
    setPtrBank(3'b010, 8'h00);
    fileAddr = 7'h23; #1;
    check("R5 0x123 untouched", rdData, 8'h3C);

    // R6: wrEn low stores nothing
    wrData = 8'h11; wrEn = 1'b0; fileAddr = 7'h23;
    tick(); #1;
    check("R6 no write when disabled", rdData, 8'h3C);

    // R8: pointer load takes effect only at the edge
    setPtrBank(3'b000, 8'h95);
    fileAddr = 7'h00; ptrIn = 8'h23; ptrLoad = 1'b1; #1;
    check("R8 old pointer before edge", rdData, 8'hA5);
    tick(); ptrLoad = 1'b0; #1;
    check("R8 new pointer after edge", effAddr, 9'h023);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule